// File: doc/BRIEF.md
# Reduced Four-Class Mealy Sequence Machine

This block is a synchronous Mealy machine that reads one serial bit per qualified cycle and produces one output bit. Its behaviour comes from a fixed eight-state transition and output table. That table collapses to four equivalence classes, and only those four classes are built in hardware. The classes are named P, Q, R and S. P is the class of the table's start state.

A strobe, `in_valid`, qualifies each input bit. The class register moves only on a rising clock edge where the strobe is high. The output is a combinational function of the present class and the present input bit, and it is forced low whenever the strobe is low. A synchronous, active-high reset returns the machine to class P.

A parameter selects the form of the class register: a two-bit binary register or a four-bit one-hot register. The behaviour at the ports is the same for both.

Top module: `seqm_reduced_fsm`

## Requirements
- R1: A clock edge with `rst` high leaves the machine in class P, which shows at the ports as `out_z`=1 for `in_x`=0 and `out_z`=0 for `in_x`=1 while `in_valid` is high.
- R2: From class P, a qualified edge with `in_x`=0 stays in P, and with `in_x`=1 moves to R.
- R3: From class Q, a qualified edge with `in_x`=0 moves to R, and with `in_x`=1 moves to S.
- R4: From class R, a qualified edge with `in_x`=0 moves to P, and with `in_x`=1 moves to Q.
- R5: From class S, a qualified edge with `in_x`=0 stays in S, and with `in_x`=1 moves to P.
- R6: While `in_valid` is high, `out_z` is the inverse of `in_x` in P, equals `in_x` in Q, and is 0 in R and in S, in the same cycle as the input bit.
- R7: While `in_valid` is low, `out_z` is 0 whatever `in_x` is.
- R8: An edge with `in_valid` low leaves the class unchanged, whatever `in_x` is.
- R9: Reset takes priority over a qualified input bit on the same edge.
- R10: For every input sequence, on every qualified cycle `out_z` equals the output of the unreduced eight-state table started in its first state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to class P |
| in_valid | input | 1 | Qualifies `in_x` for the present cycle |
| in_x | input | 1 | Serial input bit |
| out_z | output | 1 | Mealy output bit, low when `in_valid` is low |

## Verification
A wrong class does not always show at once. The two output-silent classes R and S give identical outputs for one cycle, so a swap between them shows only one qualified bit later, after a 1 has been applied. A corrupted P or Q shows in the same cycle for one of the two values of `in_x`. For this reason every length-ten input sequence is compared against the eight-state table. Random idle and reset cycles are inserted into these sequences, so that a divergence of any class has room to reach `out_z` within the sequence.

// File: rtl/seqm_pkg.sv
package seqm_pkg;

  // Equivalence classes of the reduced machine
  typedef enum logic [1:0] {
    CLS_P = 2'd0,
    CLS_Q = 2'd1,
    CLS_R = 2'd2,
    CLS_S = 2'd3
  } cls_t;

  localparam int unsigned CLS_W     = $bits(cls_t);
  localparam int unsigned CLS_COUNT = 1 << CLS_W;

endpackage

// File: rtl/seqm_next_logic.sv
module seqm_next_logic
  import seqm_pkg::*;
(
  input  cls_t cur,
  input  logic x,
  output cls_t nxt
);

  always_comb begin
    unique case (cur)
      CLS_P:   nxt = x ? CLS_R : CLS_P;
      CLS_Q:   nxt = x ? CLS_S : CLS_R;
      CLS_R:   nxt = x ? CLS_Q : CLS_P;
      CLS_S:   nxt = x ? CLS_P : CLS_S;
      default: nxt = CLS_P;
    endcase
  end

endmodule

// File: rtl/seqm_out_logic.sv
module seqm_out_logic
  import seqm_pkg::*;
(
  input  cls_t cur,
  input  logic x,
  input  logic vld,
  output logic z
);

  logic z_raw;

  always_comb begin
    unique case (cur)
      CLS_P:   z_raw = ~x;
      CLS_Q:   z_raw = x;
      default: z_raw = 1'b0;
    endcase
  end

  assign z = vld & z_raw;

endmodule

// File: rtl/seqm_state_reg.sv
module seqm_state_reg
  import seqm_pkg::*;
#(
  parameter bit ONE_HOT_STATE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  cls_t d,
  output cls_t q
);

  generate
    if (ONE_HOT_STATE) begin : g_onehot
      logic [CLS_COUNT-1:0] hot_q;
      logic [CLS_COUNT-1:0] hot_d;

      assign hot_d = CLS_COUNT'(1) << d;

      always_ff @(posedge clk) begin
        if (rst) begin
          hot_q <= CLS_COUNT'(1) << CLS_P;
        end else if (en) begin
          hot_q <= hot_d;
        end
      end

      always_comb begin
        q = CLS_P;
        for (int i = 0; i < CLS_COUNT; i++) begin
          if (hot_q[i]) q = cls_t'(CLS_W'(i));
        end
      end
    end else begin : g_binary
      cls_t bin_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          bin_q <= CLS_P;
        end else if (en) begin
          bin_q <= d;
        end
      end

      assign q = bin_q;
    end
  endgenerate

endmodule

// File: rtl/seqm_reduced_fsm.sv
module seqm_reduced_fsm
  import seqm_pkg::*;
#(
  parameter bit ONE_HOT_STATE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_x,
  output logic out_z
);

  cls_t cls_q;
  cls_t cls_d;

  seqm_next_logic u_next (
    .cur (cls_q),
    .x   (in_x),
    .nxt (cls_d)
  );

  seqm_state_reg #(
    .ONE_HOT_STATE (ONE_HOT_STATE)
  ) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (in_valid),
    .d   (cls_d),
    .q   (cls_q)
  );

  seqm_out_logic u_out (
    .cur (cls_q),
    .x   (in_x),
    .vld (in_valid),
    .z   (out_z)
  );

endmodule

// File: rtl/seqm_reduced_fsm_chk.sv
module seqm_reduced_fsm_chk
  import seqm_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_x,
  input logic out_z,
  input cls_t cls
);

  logic rst_prev_q;

  always_ff @(posedge clk) rst_prev_q <= rst;

  // R1 / R9: any edge taken with reset high lands in P
  always @(posedge clk) begin
    if (rst_prev_q === 1'b1) begin
      p_reset_to_p_r1: assert (cls == CLS_P)
        else $error("reset did not reach class P");
    end
  end

  p_p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_P) |=> (cls == ($past(in_x) ? CLS_R : CLS_P)));

  p_q_step_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_Q) |=> (cls == ($past(in_x) ? CLS_S : CLS_R)));

  p_r_step_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_R) |=> (cls == ($past(in_x) ? CLS_Q : CLS_P)));

  p_s_step_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_S) |=> (cls == ($past(in_x) ? CLS_P : CLS_S)));

  p_silent_out_r6: assert property (@(posedge clk) disable iff (rst)
    (cls == CLS_R || cls == CLS_S) |-> !out_z);

  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !out_z);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cls));

endmodule

bind seqm_reduced_fsm seqm_reduced_fsm_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_x     (in_x),
  .out_z    (out_z),
  .cls      (cls_q)
);

// File: tb/seqm_reduced_fsm_bench.sv
module seqm_reduced_fsm_bench;

  localparam int unsigned SEQ_LEN  = 10;
  localparam int unsigned WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_x = 1'b0;
  logic out_z;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  seqm_reduced_fsm u_seqm_reduced_fsm (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_x     (in_x),
    .out_z    (out_z)
  );

  // Unreduced table, states 0..7 = a..h
  function automatic int tbl_next(int s, logic x);
    case (s)
      0: return x ? 2 : 7;
      1: return x ? 3 : 2;
      2: return x ? 1 : 7;
      3: return x ? 7 : 5;
      4: return x ? 5 : 2;
      5: return x ? 6 : 5;
      6: return x ? 2 : 6;
      default: return x ? 2 : 0;
    endcase
  endfunction

  function automatic logic tbl_out(int s, logic x);
    if (x) return (s == 1 || s == 4);
    return (s == 0 || s == 6 || s == 7);
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic r, input logic v, input logic x, output logic z);
    @(negedge clk);
    rst = r; in_valid = v; in_x = x;
    #2;
    z = out_z;
    @(posedge clk);
  endtask

  task automatic do_reset();
    logic z;
    drive(1'b1, 1'b0, 1'b0, z);
  endtask

  task automatic walk(input int n, input logic [7:0] bits);
    logic z;
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, bits[i], z);
  endtask

  // Reads the class through the ports; for R and S one extra step with x=1
  task automatic probe(input string req, input byte cls);
    logic z0, z1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b1; in_x = 1'b0;
    #2 z0 = out_z;
    in_x = 1'b1;
    #2 z1 = out_z;
    in_valid = 1'b0;
    case (cls)
      "P": check(req, {z0, z1}, 2'b10);
      "Q": check(req, {z0, z1}, 2'b01);
      default: begin
        check(req, {z0, z1}, 2'b00);
        @(posedge clk);
        walk(1, 8'b1);
        probe(req, (cls == "R") ? "Q" : "P");
      end
    endcase
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    logic z;
    int   st;
    repeat (2) @(posedge clk);

    // R1: reset state
    do_reset(); probe("R1 reset", "P");
    // R2: P transitions
    do_reset(); walk(1, 8'b0); probe("R2 P-0", "P");
    do_reset(); walk(1, 8'b1); probe("R2 P-1", "R");
    // R4: R transitions
    do_reset(); walk(2, 8'b01); probe("R4 R-0", "P");
    do_reset(); walk(2, 8'b11); probe("R4 R-1", "Q");
    // R3: Q transitions
    do_reset(); walk(3, 8'b011); probe("R3 Q-0", "R");
    do_reset(); walk(3, 8'b111); probe("R3 Q-1", "S");
    // R5: S transitions
    do_reset(); walk(4, 8'b0111); probe("R5 S-0", "S");
    do_reset(); walk(4, 8'b1111); probe("R5 S-1", "P");
    // R6: outputs in each class
    do_reset(); walk(2, 8'b11);
    drive(1'b0, 1'b1, 1'b1, z); check("R6 Q out x=1", {1'b0, z}, 2'b01);
    drive(1'b0, 1'b1, 1'b0, z); check("R6 S out x=0", {1'b0, z}, 2'b00);
    // R7 and R8: idle cycles from Q
    do_reset(); walk(2, 8'b11);
    drive(1'b0, 1'b0, 1'b1, z); check("R7 idle x=1", {1'b0, z}, 2'b00);
    drive(1'b0, 1'b0, 1'b0, z); check("R7 idle x=0", {1'b0, z}, 2'b00);
    drive(1'b0, 1'b0, 1'b1, z);
    probe("R8 hold Q", "Q");
    // R9: reset beats a qualified bit
    do_reset(); walk(2, 8'b11);
    drive(1'b1, 1'b1, 1'b1, z);
    probe("R9 reset priority", "P");

    // R10: every length-ten sequence against the eight-state table
    for (int seq = 0; seq < (1 << SEQ_LEN); seq++) begin
      do_reset();
      st = 0;
      for (int i = 0; i < SEQ_LEN; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[2:0] == 3'b000) begin
          drive(1'b0, 1'b0, lf[5], z);
          check("R7 sweep idle", {1'b0, z}, 2'b00);
        end else if (lf[6:0] == 7'h7F) begin
          drive(1'b1, 1'b1, lf[8], z);
          st = 0;
        end
        drive(1'b0, 1'b1, seq[i], z);
        check("R10 table match", {1'b0, z}, {1'b0, tbl_out(st, seq[i])});
        st = tbl_next(st, seq[i]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule